// File: doc/BRIEF.md
# Memory Type Range Resolver

This block turns a physical address into an 8-bit cache memory type. The type comes from a set of range registers. A control register holds a global enable, a low-memory table enable and a fallback type. For the first megabyte, 88 per-slot type bytes cover the space at three granularities: 64 KiB slots, then 16 KiB slots, then 4 KiB slots. Above that, and whenever the table is off, a parameterised number of base/mask entry pairs are used.

When several entries cover the same address, their types are folded into one by cache-type precedence. When nothing covers the address, the fallback type is returned. While the global enable is clear, every lookup returns the invalid code.

Software loads every register through one write port. A lookup is a valid-qualified request. The answer comes back registered, one cycle later.

Top module: `memtype_resolver`

## Requirements
- R1: After reset, `rsp_valid` is low and every register holds zero, so lookups return the invalid code 0xFF until the global enable is set.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high, and low otherwise. The type uses the register state of the request cycle, so a write in that same cycle affects only later lookups.
- R3: A write with `wr_kind`=0 loads the control register. `wr_data[7:0]` is the fallback type, bit 10 is the low-memory table enable and bit 11 is the global enable. While bit 11 is clear, every response type is 0xFF.
- R4: For an address below 0x100000, when the global enable and the table enable are both set, the table byte is returned and the base/mask entries are ignored. With the table enable clear, those addresses resolve through the entries.
- R5: A write with `wr_kind`=1 loads table byte `wr_idx` (0..87) from `wr_data[7:0]`. The slots are mapped as follows:
  - Addresses 0x00000 to 0x7FFFF use slot addr>>16.
  - Addresses 0x80000 to 0xBFFFF use slot 8+((addr-0x80000)>>14).
  - Addresses 0xC0000 to 0xFFFFF use slot 24+((addr-0xC0000)>>12).
- R6: A write with `wr_kind`=2 loads the base of entry `wr_idx`, with its type in `wr_data[7:0]`. A write with `wr_kind`=3 loads its mask, with the active flag in `wr_data[11]`. Bits 11:8 of a base write and bits 10:0 of a mask write do not affect matching. An entry with a clear active flag never matches.
- R7: An active entry covers an address when (addr & mask) == (base & mask), compared on bits 12 and up.
- R8: If any covering entry has type UC (0x00), the result is UC.
- R9: If the covering entries hold only WB (0x06) and WT (0x04), both present, the result is WT.
- R10: If all covering entries hold the same type, that type is returned. Any other mix of types (for example WC 0x01 with WB) gives UC.
- R11: If no entry covers the address, and the table path is not taken, the fallback type is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write target: 0 control, 1 table byte, 2 entry base, 3 entry mask |
| wr_idx | input | IDX_W (7) | Table slot or entry number |
| wr_data | input | PA_W (36) | Write data |
| req_valid | input | 1 | Lookup request |
| req_addr | input | PA_W (36) | Physical address to resolve |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_type | output | 8 | Resolved memory type, 0xFF when disabled |

## Verification
The assertions take for granted that `req_valid` and `req_addr` carry known values whenever the block is out of reset. They also take for granted that each entry's mask describes a contiguous range; overlaps are judged only by the mask compare.

The stimulus drives every input at the falling edge and holds it through a full cycle. It keeps every request address inside the 36-bit space, and builds masks only from power-of-two sizes aligned to their bases. Overlapping entries are set up on purpose to reach each precedence case.

// File: rtl/memtype_pkg.sv
package memtype_pkg;
   typedef logic [7:0] mtype_t;

   localparam mtype_t MT_UC      = 8'h00;
   localparam mtype_t MT_WC      = 8'h01;
   localparam mtype_t MT_WT      = 8'h04;
   localparam mtype_t MT_WP      = 8'h05;
   localparam mtype_t MT_WB      = 8'h06;
   localparam mtype_t MT_INVALID = 8'hFF;

   typedef enum logic [1:0] {
      WK_CTRL  = 2'd0,
      WK_TABLE = 2'd1,
      WK_BASE  = 2'd2,
      WK_MASK  = 2'd3
   } wr_kind_e;

   localparam int TABLE_SLOTS = 88;
   localparam int LOW_SPAN_W  = 20;
   localparam int PAGE_LSB    = 12;

   // Pairwise precedence fold of two covering types.
   function automatic mtype_t mt_combine(mtype_t a, mtype_t b);
      if (a == MT_UC || b == MT_UC)
         return MT_UC;
      else if (a == b)
         return a;
      else if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB))
         return MT_WT;
      else
         return MT_UC;
   endfunction
endpackage

// File: rtl/mt_table_bank.sv
module mt_table_bank
   import memtype_pkg::*;
#(
   parameter int SLOTS  = TABLE_SLOTS,
   parameter int IDX_W  = 7,
   parameter int SPAN_W = LOW_SPAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [7:0]        wr_byte,
   input  logic [SPAN_W-1:0] addr,
   output mtype_t            type_o
);
   logic [7:0]       tab_q [SLOTS];
   logic [IDX_W-1:0] slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) tab_q[i] <= '0;
      end else if (wr_en && (wr_idx < IDX_W'(SLOTS))) begin
         tab_q[wr_idx] <= wr_byte;
      end
   end

   // Three granularities: 64 KiB, 16 KiB, 4 KiB.
   always_comb begin
      if (!addr[19])
         slot = IDX_W'(addr[18:16]);
      else if (!addr[18])
         slot = IDX_W'(8) + IDX_W'(addr[17:14]);
      else
         slot = IDX_W'(24) + IDX_W'(addr[17:12]);
   end

   logic unused_lo;
   assign unused_lo = ^addr[11:0];

   assign type_o = tab_q[slot];
endmodule

// File: rtl/mt_var_bank.sv
module mt_var_bank
   import memtype_pkg::*;
#(
   parameter int N_VAR = 8,
   parameter int PA_W  = 36,
   parameter int IDX_W = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_base,
   input  logic                 wr_mask,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [PA_W-1:0]      wr_data,
   input  logic [PA_W-1:0]      addr,
   output logic [N_VAR-1:0]     hit,
   output mtype_t [N_VAR-1:0]   types
);
   localparam int PG_W = PA_W - PAGE_LSB;

   logic unused_bits;
   assign unused_bits = ^{wr_data[10:8], addr[PAGE_LSB-1:0]};

   for (genvar e = 0; e < N_VAR; e++) begin : g_ent
      logic [PG_W-1:0] base_pg;
      logic [PG_W-1:0] mask_pg;
      mtype_t          typ;
      logic            act;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_pg <= '0;
            mask_pg <= '0;
            typ     <= MT_UC;
            act     <= 1'b0;
         end else begin
            if (wr_base && wr_idx == IDX_W'(e)) begin
               base_pg <= wr_data[PA_W-1:PAGE_LSB];
               typ     <= wr_data[7:0];
            end
            if (wr_mask && wr_idx == IDX_W'(e)) begin
               mask_pg <= wr_data[PA_W-1:PAGE_LSB];
               act     <= wr_data[11];
            end
         end
      end

      assign hit[e]   = act && (((addr[PA_W-1:PAGE_LSB] ^ base_pg) & mask_pg) == '0);
      assign types[e] = typ;
   end
endmodule

// File: rtl/mt_merge.sv
module mt_merge
   import memtype_pkg::*;
#(
   parameter int N_VAR = 8
) (
   input  logic [N_VAR-1:0]   hit,
   input  mtype_t [N_VAR-1:0] types,
   input  mtype_t             def_type,
   output mtype_t             merged,
   output logic               any_hit
);
   always_comb begin
      mtype_t acc;
      logic   seen;
      acc  = def_type;
      seen = 1'b0;
      for (int e = 0; e < N_VAR; e++) begin
         if (hit[e]) begin
            acc  = seen ? mt_combine(acc, types[e]) : types[e];
            seen = 1'b1;
         end
      end
      merged  = acc;
      any_hit = seen;
   end
endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
   import memtype_pkg::*;
#(
   parameter int PA_W      = 36,
   parameter int N_VAR     = 8,
   parameter int IDX_W     = 7,
   parameter bit HAS_TABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_kind,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PA_W-1:0]  wr_data,
   input  logic             req_valid,
   input  logic [PA_W-1:0]  req_addr,
   output logic             rsp_valid,
   output logic [7:0]       rsp_type
);
   localparam int HI_W = PA_W - LOW_SPAN_W;

   if (PA_W < LOW_SPAN_W + 1 || PA_W > 64) begin : g_bad_pa
      $error("memtype_resolver: PA_W out of range");
   end
   if (N_VAR < 1 || (2 ** IDX_W) < N_VAR || (2 ** IDX_W) < TABLE_SLOTS) begin : g_bad_idx
      $error("memtype_resolver: IDX_W too small or N_VAR zero");
   end

   // control register
   mtype_t def_type;
   logic   tab_en;
   logic   glob_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         def_type <= MT_UC;
         tab_en   <= 1'b0;
         glob_en  <= 1'b0;
      end else if (wr_en && wr_kind == WK_CTRL) begin
         def_type <= wr_data[7:0];
         tab_en   <= wr_data[10];
         glob_en  <= wr_data[11];
      end
   end

   // low-memory table
   mtype_t tab_type;
   logic   low_addr;
   assign low_addr = (req_addr[PA_W-1:LOW_SPAN_W] == HI_W'(0));

   if (HAS_TABLE) begin : g_table
      mt_table_bank #(.SLOTS(TABLE_SLOTS), .IDX_W(IDX_W), .SPAN_W(LOW_SPAN_W)) u_table (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en && wr_kind == WK_TABLE),
         .wr_idx  (wr_idx),
         .wr_byte (wr_data[7:0]),
         .addr    (req_addr[LOW_SPAN_W-1:0]),
         .type_o  (tab_type)
      );
   end else begin : g_no_table
      assign tab_type = MT_UC;
   end

   // base/mask entries
   logic [N_VAR-1:0]   var_hit;
   mtype_t [N_VAR-1:0] var_types;
   mtype_t             merged;
   logic               any_hit;

   mt_var_bank #(.N_VAR(N_VAR), .PA_W(PA_W), .IDX_W(IDX_W)) u_var (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_base (wr_en && wr_kind == WK_BASE),
      .wr_mask (wr_en && wr_kind == WK_MASK),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .addr    (req_addr),
      .hit     (var_hit),
      .types   (var_types)
   );

   mt_merge #(.N_VAR(N_VAR)) u_merge (
      .hit      (var_hit),
      .types    (var_types),
      .def_type (def_type),
      .merged   (merged),
      .any_hit  (any_hit)
   );

   // resolve and register
   logic   use_table;
   mtype_t next_type;
   assign use_table = HAS_TABLE && tab_en && low_addr;

   always_comb begin
      if (!glob_en)
         next_type = MT_INVALID;
      else if (use_table)
         next_type = tab_type;
      else
         next_type = merged;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_type  <= MT_INVALID;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) rsp_type <= next_type;
      end
   end

   // assertion helper: any covering entry of type UC
   logic hit_uc;
   always_comb begin
      hit_uc = 1'b0;
      for (int e = 0; e < N_VAR; e++)
         if (var_hit[e] && var_types[e] == MT_UC) hit_uc = 1'b1;
   end

   // R2
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R2
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R3
   disabled_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !glob_en) |=> (rsp_type == MT_INVALID));
   // R8
   uc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_uc |-> (merged == MT_UC));
   // R11
   fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_hit |-> (merged == def_type));
endmodule

// File: tb/tb_memtype_resolver.sv
module tb_memtype_resolver;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_kind = '0;
   logic [6:0]  wr_idx = '0;
   logic [35:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [35:0] req_addr = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_type;

   int    errors = 0;
   int    checks = 0;
   bit    done = 0;
   string cur_tag = "R2";

   always #4 clk = ~clk;

   memtype_resolver dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
      .wr_idx(wr_idx), .wr_data(wr_data), .req_valid(req_valid),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_type(rsp_type)
   );

   // reference model state
   logic [7:0]  m_tab [88];
   logic [35:0] m_base [8];
   logic [35:0] m_mask [8];
   logic [7:0]  m_def;
   bit          m_ten, m_gen;
   bit          exp_valid;
   logic [7:0]  exp_type;
   string       exp_tag;

   function automatic logic [7:0] ref_type(logic [35:0] a);
      longint ua;
      int cnt;
      bit has_uc, all_same, only_wbwt;
      logic [7:0] first;
      ua = longint'(a);
      if (!m_gen) return 8'hFF;
      if (ua < 64'h100000 && m_ten) begin
         if (ua < 64'h80000) return m_tab[int'(ua / 65536)];
         if (ua < 64'hC0000) return m_tab[8 + int'((ua - 64'h80000) / 16384)];
         return m_tab[24 + int'((ua - 64'hC0000) / 4096)];
      end
      cnt = 0; has_uc = 0; all_same = 1; only_wbwt = 1; first = 0;
      for (int e = 0; e < 8; e++) begin
         longint pm;
         logic [7:0] t;
         if (m_mask[e][11] == 1'b0) continue;
         pm = longint'(m_mask[e]) & 64'hFFFFFF000;
         if ((ua & pm) != (longint'(m_base[e]) & pm)) continue;
         t = m_base[e][7:0];
         if (cnt == 0) first = t;
         else if (t != first) all_same = 0;
         if (t == 8'h00) has_uc = 1;
         if (t != 8'h06 && t != 8'h04) only_wbwt = 0;
         cnt++;
      end
      if (cnt == 0) return m_def;
      if (has_uc) return 8'h00;
      if (all_same) return first;
      if (only_wbwt) return 8'h04;
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 88; i++) m_tab[i] = 8'h00;
         for (int e = 0; e < 8; e++) begin m_base[e] = '0; m_mask[e] = '0; end
         m_def = 8'h00; m_ten = 0; m_gen = 0;
         exp_valid = 0; exp_type = 8'hFF;
      end else begin
         exp_valid = req_valid;
         exp_tag = cur_tag;
         if (req_valid) exp_type = ref_type(req_addr);
         if (wr_en) begin
            case (wr_kind)
               2'd0: begin m_def = wr_data[7:0]; m_ten = wr_data[10]; m_gen = wr_data[11]; end
               2'd1: if (wr_idx < 88) m_tab[wr_idx] = wr_data[7:0];
               2'd2: if (wr_idx < 8) m_base[wr_idx[2:0]] = wr_data;
               default: if (wr_idx < 8) m_mask[wr_idx[2:0]] = wr_data;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (rsp_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s: rsp_valid=%0b expected %0b", exp_tag, rsp_valid, exp_valid);
         end else if (exp_valid && rsp_type !== exp_type) begin
            errors++;
            $display("FAIL %s: rsp_type=%02h expected %02h", exp_tag, rsp_type, exp_type);
         end
      end
   end

   task automatic cyc(bit we, logic [1:0] k, int idx, logic [35:0] d,
                      bit rv, logic [35:0] a, string tag);
      @(negedge clk);
      wr_en = we; wr_kind = k; wr_idx = 7'(idx); wr_data = d;
      req_valid = rv; req_addr = a; cur_tag = tag;
   endtask

   task automatic wr(logic [1:0] k, int idx, logic [35:0] d);
      cyc(1, k, idx, d, 0, '0, "R2");
   endtask

   task automatic look(logic [35:0] a, string tag);
      cyc(0, 2'd0, 0, '0, 1, a, tag);
   endtask

   task automatic idle();
      cyc(0, 2'd0, 0, '0, 0, '0, "R2");
   endtask

   function automatic logic [35:0] mk_mask(longint size, bit act);
      logic [35:0] m;
      m = 36'(~(size - 1)) & 36'hFFFFFF000;
      return act ? (m | 36'h800) : m;
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: rsp_valid in reset=%0b expected 0", rsp_valid);
      end
      rst_n = 1'b1;
      idle();
      look(36'h012345678, "R1");
      look(36'h000050000, "R1");
      idle();
      // control: fallback WP, both enables
      wr(2'd0, 0, 36'h000000C05);
      for (int i = 0; i < 88; i++) wr(2'd1, i, 36'((i * 37 + 5) & 8'hFF));
      look(36'h000000000, "R5");
      look(36'h00007FFFF, "R5");
      look(36'h000080000, "R5");
      look(36'h0000BFFFF, "R5");
      look(36'h0000C0000, "R5");
      look(36'h0000FFFFF, "R5");
      look(36'h000045678, "R5");
      look(36'h00009C000, "R5");
      look(36'h0000DA123, "R5");
      look(36'h000100000, "R11");
      // entries
      wr(2'd2, 0, 36'h100000006);
      wr(2'd3, 0, mk_mask(64'h10000000, 1));
      look(36'h100000123, "R7");
      look(36'h110000000, "R11");
      wr(2'd2, 1, 36'h104000004);
      wr(2'd3, 1, mk_mask(64'h1000000, 1));
      look(36'h104000040, "R9");
      look(36'h108000000, "R7");
      wr(2'd2, 2, 36'h108000000);
      wr(2'd3, 2, mk_mask(64'h1000, 1));
      look(36'h108000FFF, "R8");
      look(36'h108001000, "R7");
      wr(2'd2, 3, 36'h10C000001);
      wr(2'd3, 3, mk_mask(64'h100000, 0));
      look(36'h10C000000, "R6");
      wr(2'd3, 3, mk_mask(64'h100000, 1));
      look(36'h10C000000, "R10");
      wr(2'd2, 4, 36'h100000006);
      wr(2'd3, 4, mk_mask(64'h100000000, 1));
      look(36'h100000100, "R10");
      look(36'h1F0000000, "R10");
      wr(2'd2, 5, 36'h200000F01);
      wr(2'd3, 5, mk_mask(64'h1000, 1) | 36'h7FF);
      look(36'h200000ABC, "R6");
      look(36'h200001000, "R6");
      // entry covering low memory
      wr(2'd2, 6, 36'h000000001);
      wr(2'd3, 6, mk_mask(64'h100000, 1));
      look(36'h000050000, "R4");
      wr(2'd0, 0, 36'h000000805);
      look(36'h000050000, "R4");
      look(36'h0000C3000, "R4");
      // global disable
      wr(2'd0, 0, 36'h000000405);
      look(36'h100000123, "R3");
      look(36'h000050000, "R3");
      // same-cycle write and request sees old state
      cyc(1, 2'd0, 0, 36'h000000C06, 1, 36'h300000000, "R2");
      look(36'h300000000, "R2");
      look(36'h000010000, "R2");
      idle();
      idle();
      @(negedge clk);
      done = 1;
      summary();
      $finish;
   end
endmodule